// File: doc/BRIEF.md
# Partial-Tag Early Miss Filter

This block lives in the controller of a banked cache whose bank sets span several ways at increasing distance from the controller. For every way of every bank set it keeps a short partial tag (a few low bits of the full line tag) and a valid flag. On a lookup it compares the requested partial tag against all ways of the addressed set in parallel. It returns a per-way candidate mask and a miss flag. A partial match is only a hint, and the full tag compare in the banks still decides a hit. An empty mask is always a true miss, so miss handling can begin before any bank replies.

The filter has two lookup modes. In performance mode, the result appears on the cycle after the lookup is accepted, in parallel with a normal bank search. In energy mode, the filter holds its match vector until the nearest bank reports. If that bank hit, nothing more is produced. If it missed, the filter emits the mask with the nearest way removed, so that only those banks are probed. One update port keeps the array in step with the bank set: fills into the farthest way, swaps of adjacent ways on promotion, and invalidations. A pending energy-mode match vector is transformed by the same updates, so it keeps describing the current way positions.

The controller is a three-state machine. `ST_IDLE` accepts a lookup (transition *accept*, to `ST_CMP`). `ST_CMP` performs the parallel compare. In performance mode it reports and returns (*report*, to `ST_IDLE`). In energy mode it moves on (*park*, to `ST_WAIT`). `ST_WAIT` holds the match vector until the nearest bank answers (*resolve*, to `ST_IDLE`).

Top module: `ptag_filter`

## Requirements
- R1: After reset every entry is invalid, so any lookup, including one with partial tag 0, reports `res_miss`=1 and `res_mask`=0. Also after reset, `lk_ready`=1 and `res_valid`=0.
- R2: A performance-mode lookup (`lk_energy`=0) is accepted when `lk_valid`=1 and `lk_ready`=1. Its result appears with `res_valid`=1 on the next cycle. In `res_mask`, bit i is 1 exactly when way i of the set is valid and holds the requested partial tag. Bit 0 is the nearest way and bit WAYS-1 the farthest.
- R3: Whenever `res_valid`=1, `res_miss` is 1 exactly when `res_mask` is all zero. Ways whose partial tags are equal may all be flagged.
- R4: `upd_op`=1 (fill) writes `upd_ptag` into the farthest way (WAYS-1) of set `upd_set` and marks that way valid.
- R5: `upd_op`=2 (swap) with `upd_way`=k>0 exchanges the entries of ways k and k-1 of set `upd_set`. A swap with k=0 has no effect.
- R6: `upd_op`=3 (invalidate) marks way `upd_way` of set `upd_set` invalid. `upd_op`=0 does nothing.
- R7: An energy-mode lookup (`lk_energy`=1) produces no result in `ST_CMP`. It waits in `ST_WAIT` until `near_valid`=1. If `near_hit`=1 it ends with `res_valid`=0.
- R8: When an energy-mode lookup resolves with `near_valid`=1 and `near_hit`=0, `res_valid`=1 in that same cycle. `res_mask` is then the matching ways with bit 0 forced to 0.
- R9: An update presented in the same cycle as an accepted lookup is visible to that lookup's compare.
- R10: An update to the looked-up set that arrives while an energy lookup is pending changes the pending mask in the same way it changes the array. A swap moves the bit, a fill sets the farthest bit to whether the new tag matches, and an invalidate clears the bit.
- R11: `lk_ready`=0 in `ST_CMP` and `ST_WAIT`. A `lk_valid` pulse seen there is ignored and does not start a lookup.
- R12: Updates to a set other than the one being looked up leave the pending mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_energy | input | 1 | 1 = energy mode, 0 = performance mode |
| lk_set | input | SET_W | Bank set of the lookup |
| lk_ptag | input | PTAG_W | Requested partial tag |
| lk_ready | output | 1 | Filter is idle and accepts a lookup |
| near_valid | input | 1 | Nearest-bank result is present |
| near_hit | input | 1 | Nearest bank hit |
| upd_op | input | 2 | 0 none, 1 fill, 2 swap, 3 invalidate |
| upd_set | input | SET_W | Set being updated |
| upd_way | input | WAY_W | Way for swap (with way-1) or invalidate |
| upd_ptag | input | PTAG_W | Partial tag of a filled line |
| res_valid | output | 1 | Result present this cycle |
| res_miss | output | 1 | No candidate way: start miss handling |
| res_mask | output | WAYS | Candidate ways, bit 0 nearest |

## Verification
The case that needs the most care is an update to the looked-up set that lands while a lookup is in flight. The update can arrive together with acceptance, where it must be seen by the compare. It can also arrive during the energy-mode wait, where it must reshape the parked mask. The bench drives a swap and a fill into the same set during `ST_WAIT`, and a fill together with a lookup acceptance. It then compares the reported masks against the way positions after the update. A fill into another set during the wait checks that unrelated traffic leaves the mask alone.

// File: rtl/ptf_pkg.sv
package ptf_pkg;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_FILL = 2'd1,
        UPD_SWAP = 2'd2,
        UPD_DROP = 2'd3
    } upd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMP  = 2'd1,
        ST_WAIT = 2'd2
    } fsm_e;

endpackage

// File: rtl/ptf_array.sv
module ptf_array
    import ptf_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int PTAG_W = 6,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  upd_op_e           upd_op,
    input  logic [SET_W-1:0]  upd_set,
    input  logic [WAY_W-1:0]  upd_way,
    input  logic [PTAG_W-1:0] upd_ptag,
    input  logic [SET_W-1:0]  cmp_set,
    input  logic [PTAG_W-1:0] cmp_ptag,
    output logic [WAYS-1:0]   cmp_match
);

    localparam int FAR = WAYS - 1;
    localparam logic [WAY_W-1:0] ONE_W = WAY_W'(1);

    logic [SETS-1:0][WAYS-1:0] vld_q;
    logic [PTAG_W-1:0]         tag_q [SETS][WAYS];
    logic [WAY_W-1:0]          way_lo;

    assign way_lo = upd_way - ONE_W;

    // valid flags: reset to all-invalid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            case (upd_op)
                UPD_FILL: vld_q[upd_set][FAR] <= 1'b1;
                UPD_SWAP: begin
                    if (upd_way != '0) begin
                        vld_q[upd_set][upd_way] <= vld_q[upd_set][way_lo];
                        vld_q[upd_set][way_lo]  <= vld_q[upd_set][upd_way];
                    end
                end
                UPD_DROP: vld_q[upd_set][upd_way] <= 1'b0;
                default: ;
            endcase
        end
    end

    // tag storage: no reset needed, guarded by valid flags
    always_ff @(posedge clk) begin
        case (upd_op)
            UPD_FILL: tag_q[upd_set][FAR] <= upd_ptag;
            UPD_SWAP: begin
                if (upd_way != '0) begin
                    tag_q[upd_set][upd_way] <= tag_q[upd_set][way_lo];
                    tag_q[upd_set][way_lo]  <= tag_q[upd_set][upd_way];
                end
            end
            default: ;
        endcase
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign cmp_match[w] = vld_q[cmp_set][w] && (tag_q[cmp_set][w] == cmp_ptag);
    end

    assert_reset_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (vld_q == '0));

    assert_fill_far_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_op == UPD_FILL) |=> vld_q[$past(upd_set)][FAR]);

    assert_drop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_op == UPD_DROP) |=> !vld_q[$past(upd_set)][$past(upd_way)]);

endmodule

// File: rtl/ptf_ctrl.sv
module ptf_ctrl
    import ptf_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int PTAG_W = 6,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_energy,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [PTAG_W-1:0] lk_ptag,
    input  logic              near_valid,
    input  logic              near_hit,
    input  upd_op_e           upd_op,
    input  logic [SET_W-1:0]  upd_set,
    input  logic [WAY_W-1:0]  upd_way,
    input  logic [PTAG_W-1:0] upd_ptag,
    input  logic [WAYS-1:0]   cmp_match,
    output logic [SET_W-1:0]  cmp_set,
    output logic [PTAG_W-1:0] cmp_ptag,
    output logic              lk_ready,
    output logic              res_valid,
    output logic              res_miss,
    output logic [WAYS-1:0]   res_mask
);

    localparam int FAR = WAYS - 1;
    localparam logic [WAY_W-1:0] ONE_W = WAY_W'(1);
    localparam logic [WAYS-1:0] NEAR_BIT = WAYS'(1);

    fsm_e              state_q, state_d;
    logic [SET_W-1:0]  q_set;
    logic [PTAG_W-1:0] q_ptag;
    logic              q_energy;
    logic [WAYS-1:0]   match_q, base, adj;
    logic [WAY_W-1:0]  way_lo;

    assign cmp_set  = q_set;
    assign cmp_ptag = q_ptag;
    assign way_lo   = upd_way - ONE_W;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (lk_valid) state_d = ST_CMP;
            ST_CMP:  state_d = q_energy ? ST_WAIT : ST_IDLE;
            ST_WAIT: if (near_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // pending mask follows updates to the looked-up set
    always_comb begin
        base = (state_q == ST_CMP) ? cmp_match : match_q;
        adj  = base;
        if (upd_set == q_set) begin
            case (upd_op)
                UPD_FILL: adj[FAR] = (upd_ptag == q_ptag);
                UPD_SWAP: begin
                    if (upd_way != '0) begin
                        adj[upd_way] = base[way_lo];
                        adj[way_lo]  = base[upd_way];
                    end
                end
                UPD_DROP: adj[upd_way] = 1'b0;
                default: ;
            endcase
        end
    end

    // lookup context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_set    <= '0;
            q_ptag   <= '0;
            q_energy <= 1'b0;
            match_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && lk_valid) begin
                q_set    <= lk_set;
                q_ptag   <= lk_ptag;
                q_energy <= lk_energy;
            end
            if (state_q == ST_CMP || state_q == ST_WAIT) begin
                match_q <= adj;
            end
        end
    end

    // outputs
    always_comb begin
        lk_ready  = 1'b0;
        res_valid = 1'b0;
        res_miss  = 1'b0;
        res_mask  = '0;
        unique case (state_q)
            ST_IDLE: lk_ready = 1'b1;
            ST_CMP: begin
                if (!q_energy) begin
                    res_valid = 1'b1;
                    res_mask  = cmp_match;
                    res_miss  = (cmp_match == '0);
                end
            end
            ST_WAIT: begin
                if (near_valid && !near_hit) begin
                    res_valid = 1'b1;
                    res_mask  = match_q & ~NEAR_BIT;
                    res_miss  = ((match_q & ~NEAR_BIT) == '0);
                end
            end
            default: ;
        endcase
    end

    assert_perf_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !q_energy) |-> $past(lk_valid && lk_ready));

    assert_near_hit_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (near_valid && near_hit && q_energy) |-> !res_valid);

    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !lk_ready);

endmodule

// File: rtl/ptag_filter.sv
module ptag_filter
    import ptf_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int PTAG_W = 6,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_energy,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [PTAG_W-1:0] lk_ptag,
    output logic              lk_ready,
    input  logic              near_valid,
    input  logic              near_hit,
    input  logic [1:0]        upd_op,
    input  logic [SET_W-1:0]  upd_set,
    input  logic [WAY_W-1:0]  upd_way,
    input  logic [PTAG_W-1:0] upd_ptag,
    output logic              res_valid,
    output logic              res_miss,
    output logic [WAYS-1:0]   res_mask
);

    upd_op_e           op;
    logic [SET_W-1:0]  cmp_set;
    logic [PTAG_W-1:0] cmp_ptag;
    logic [WAYS-1:0]   cmp_match;

    assign op = upd_op_e'(upd_op);

    ptf_array #(.SETS(SETS), .WAYS(WAYS), .PTAG_W(PTAG_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_op   (op),
        .upd_set  (upd_set),
        .upd_way  (upd_way),
        .upd_ptag (upd_ptag),
        .cmp_set  (cmp_set),
        .cmp_ptag (cmp_ptag),
        .cmp_match(cmp_match)
    );

    ptf_ctrl #(.SETS(SETS), .WAYS(WAYS), .PTAG_W(PTAG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_energy (lk_energy),
        .lk_set    (lk_set),
        .lk_ptag   (lk_ptag),
        .near_valid(near_valid),
        .near_hit  (near_hit),
        .upd_op    (op),
        .upd_set   (upd_set),
        .upd_way   (upd_way),
        .upd_ptag  (upd_ptag),
        .cmp_match (cmp_match),
        .cmp_set   (cmp_set),
        .cmp_ptag  (cmp_ptag),
        .lk_ready  (lk_ready),
        .res_valid (res_valid),
        .res_miss  (res_miss),
        .res_mask  (res_mask)
    );

    assert_miss_matches_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_miss == (res_mask == '0)));

endmodule

// File: tb/test_ptag_filter.sv
`timescale 1ns/1ps
module test_ptag_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lk_valid = 1'b0, lk_energy = 1'b0;
    logic [2:0] lk_set = '0;
    logic [5:0] lk_ptag = '0;
    logic       lk_ready;
    logic       near_valid = 1'b0, near_hit = 1'b0;
    logic [1:0] upd_op = 2'd0;
    logic [2:0] upd_set = '0;
    logic [1:0] upd_way = '0;
    logic [5:0] upd_ptag = '0;
    logic       res_valid, res_miss;
    logic [3:0] res_mask;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ptag_filter i_ptag_filter (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_energy(lk_energy), .lk_set(lk_set), .lk_ptag(lk_ptag),
        .lk_ready(lk_ready), .near_valid(near_valid), .near_hit(near_hit),
        .upd_op(upd_op), .upd_set(upd_set), .upd_way(upd_way), .upd_ptag(upd_ptag),
        .res_valid(res_valid), .res_miss(res_miss), .res_mask(res_mask)
    );

    // perf lookups after setup: {set, ptag, expected mask}
    localparam logic [12:0] VEC [7] = '{
        {3'd2, 6'h11, 4'b1001},
        {3'd2, 6'h22, 4'b0100},
        {3'd2, 6'h33, 4'b0000},
        {3'd5, 6'h11, 4'b1000},
        {3'd5, 6'h22, 4'b0000},
        {3'd0, 6'h11, 4'b0000},
        {3'd7, 6'h00, 4'b0000}
    };

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic upd(logic [1:0] op, logic [2:0] s, logic [1:0] w, logic [5:0] p);
        @(negedge clk);
        upd_op = op; upd_set = s; upd_way = w; upd_ptag = p;
        @(negedge clk);
        upd_op = 2'd0;
    endtask

    task automatic perf(string req, logic [2:0] s, logic [5:0] p, logic [3:0] exp);
        @(negedge clk);
        lk_valid = 1'b1; lk_energy = 1'b0; lk_set = s; lk_ptag = p;
        @(negedge clk);
        lk_valid = 1'b0;
        #1;
        check(req, "res_valid", 32'(res_valid), 32'd1);
        check(req, "res_mask", 32'(res_mask), 32'(exp));
        check("R3", "res_miss", 32'(res_miss), 32'(exp == 4'd0));
    endtask

    task automatic energy(string req, logic [2:0] s, logic [5:0] p, logic hit,
                          logic [1:0] op, logic [2:0] us, logic [1:0] uw, logic [5:0] up,
                          logic [3:0] exp);
        @(negedge clk);
        lk_valid = 1'b1; lk_energy = 1'b1; lk_set = s; lk_ptag = p;
        @(negedge clk);
        lk_valid = 1'b0;
        #1;
        check("R7", "res_valid in compare", 32'(res_valid), 32'd0);
        @(negedge clk);
        upd_op = op; upd_set = us; upd_way = uw; upd_ptag = up;
        lk_valid = 1'b1; lk_set = 3'd1; lk_ptag = 6'h3f;
        #1;
        check("R11", "lk_ready in wait", 32'(lk_ready), 32'd0);
        @(negedge clk);
        upd_op = 2'd0; lk_valid = 1'b0;
        near_valid = 1'b1; near_hit = hit;
        #1;
        if (hit) begin
            check("R7", "res_valid on near hit", 32'(res_valid), 32'd0);
        end else begin
            check(req, "res_valid", 32'(res_valid), 32'd1);
            check(req, "res_mask", 32'(res_mask), 32'(exp));
            check("R3", "res_miss", 32'(res_miss), 32'(exp == 4'd0));
        end
        @(negedge clk);
        near_valid = 1'b0; near_hit = 1'b0;
        #1;
        check("R11", "back to idle", 32'(lk_ready), 32'd1);
        check("R11", "no stray result", 32'(res_valid), 32'd0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "lk_ready after reset", 32'(lk_ready), 32'd1);
        check("R1", "res_valid after reset", 32'(res_valid), 32'd0);
        perf("R1", 3'd3, 6'h00, 4'b0000);

        // setup: R4 fills, R5 swaps
        upd(2'd1, 3'd2, 2'd0, 6'h11);
        upd(2'd2, 3'd2, 2'd3, 6'h00);
        upd(2'd2, 3'd2, 2'd2, 6'h00);
        upd(2'd2, 3'd2, 2'd1, 6'h00);
        upd(2'd1, 3'd2, 2'd0, 6'h22);
        upd(2'd2, 3'd2, 2'd3, 6'h00);
        upd(2'd1, 3'd2, 2'd0, 6'h11);
        upd(2'd1, 3'd5, 2'd0, 6'h11);

        for (int i = 0; i < 7; i++) begin
            perf("R2", VEC[i][12:10], VEC[i][9:4], VEC[i][3:0]);
        end

        // R5: swap at way 0 ignored
        upd(2'd2, 3'd2, 2'd0, 6'h00);
        perf("R5", 3'd2, 6'h11, 4'b1001);

        // R6: invalidate
        upd(2'd3, 3'd5, 2'd3, 6'h00);
        perf("R6", 3'd5, 6'h11, 4'b0000);

        // R9: fill in the same cycle as acceptance
        @(negedge clk);
        lk_valid = 1'b1; lk_energy = 1'b0; lk_set = 3'd6; lk_ptag = 6'h2a;
        upd_op = 2'd1; upd_set = 3'd6; upd_ptag = 6'h2a;
        @(negedge clk);
        lk_valid = 1'b0; upd_op = 2'd0;
        #1;
        check("R9", "res_mask", 32'(res_mask), 32'h8);

        // energy mode
        energy("R7",  3'd2, 6'h11, 1'b1, 2'd0, 3'd0, 2'd0, 6'h00, 4'b0000);
        energy("R8",  3'd2, 6'h11, 1'b0, 2'd0, 3'd0, 2'd0, 6'h00, 4'b1000);
        energy("R10", 3'd2, 6'h22, 1'b0, 2'd2, 3'd2, 2'd2, 6'h00, 4'b0010);
        energy("R10", 3'd2, 6'h33, 1'b0, 2'd1, 3'd2, 2'd0, 6'h33, 4'b1000);
        energy("R12", 3'd2, 6'h11, 1'b0, 2'd1, 3'd4, 2'd0, 6'h11, 4'b0000);

        // array reflects the updates made during the waits
        perf("R5", 3'd2, 6'h22, 4'b0010);
        perf("R4", 3'd2, 6'h33, 4'b1000);
        perf("R12", 3'd4, 6'h11, 4'b1000);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule